// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is the register-and-bus core of a small 16-bit accumulator machine. Six registers and a word-addressed memory all sit on one common 16-bit bus, and a 3-bit select code decides which of them drives it. The address register (AR) and the program counter (PC) are 12 bits wide. The data register (DR), accumulator (AC), instruction register (IR) and temporary register (TR) are 16 bits wide.

Each register has its own load, increment and clear strobes, so a sequencer outside the block can move a word from any source into any set of registers on one clock edge. The memory holds 4096 words and is always addressed by AR. It can be read onto the bus or written from the bus. The accumulator takes its load value from an external arithmetic result input instead of from the bus. ALU functions, instruction decode, sequencing and I/O handshakes are left to neighbouring blocks.

Top module: `sbd_top`

## Requirements
- R1: After reset is asserted (rst_n low, asynchronous), every register output reads 0.
- R2: The bus select code works as follows:
  - 0 drives all zeros.
  - 1 selects AR, 2 PC, 3 DR, 4 AC, 5 IR, 6 TR and 7 memory.
  - No more than one source is enabled at a time.
- R3: When AR or PC (select 1 or 2) drives the bus, it is zero-extended, so bus bits 15:12 are 0.
- R4: A register whose load bit is set captures a value on the rising edge:
  - AR and PC take the low 12 bits of the bus.
  - DR, IR and TR take the full bus.
  - AC takes the alu_result input.
- R5: A register whose increment bit is set adds 1 on the edge, wrapping modulo its own width: 0xFFF goes to 0x000 in 12 bits, and 0xFFFF goes to 0x0000 in 16 bits.
- R6: When several strobes for one register are set together, clear beats load and load beats increment.
- R7: With mem_we high, the bus value is stored on the rising edge at the word that AR addresses in that cycle.
- R8: Select code 7 puts the memory word at the current AR address onto the bus combinationally, in the same cycle.
- R9: A register with none of its strobes set holds its value.
- R10: Strobe vectors use bit 0 for AR, bit 1 for PC, bit 2 for DR, bit 3 for AC, bit 4 for IR and bit 5 for TR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of all registers |
| bus_sel | input | 3 | Bus source select code |
| reg_ld | input | 6 | Per-register load strobes |
| reg_inc | input | 6 | Per-register increment strobes |
| reg_clr | input | 6 | Per-register clear strobes |
| mem_we | input | 1 | Memory write strobe (stores bus at AR) |
| alu_result | input | 16 | Load value for the accumulator |
| bus_data | output | 16 | Current value of the common bus |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |

## Verification
Every register is a port, so a wrong strobe priority or a wrong wrap shows up on the register's output at the first falling edge after the faulty capture. A wrong bus source shows on bus_data in the same cycle it is selected. A misplaced memory write stays hidden until AR returns to the affected word and select code 7 reads it. The bench therefore mirrors memory contents in a model and compares every read of an address it has already written.

// File: rtl/sbd_pkg.sv
`timescale 1ns/1ps
package sbd_pkg;
  localparam int NUM_REGS = 6;
  localparam int IDX_AR = 0;
  localparam int IDX_PC = 1;
  localparam int IDX_DR = 2;
  localparam int IDX_AC = 3;
  localparam int IDX_IR = 4;
  localparam int IDX_TR = 5;

  typedef enum logic [2:0] {
    SEL_ZERO = 3'd0,
    SEL_AR   = 3'd1,
    SEL_PC   = 3'd2,
    SEL_DR   = 3'd3,
    SEL_AC   = 3'd4,
    SEL_IR   = 3'd5,
    SEL_TR   = 3'd6,
    SEL_MEM  = 3'd7
  } bus_sel_e;

  // one-hot source enable for the AND-OR bus, bit k = select code k+1
  function automatic logic [6:0] sel_decode(input logic [2:0] sel);
    logic [6:0] en;
    en = '0;
    if (sel != 3'd0) en[sel - 3'd1] = 1'b1;
    return en;
  endfunction
endpackage

// File: rtl/sbd_reg_cell.sv
`timescale 1ns/1ps
module sbd_reg_cell #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic         inc,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // priority events brought out as named wires
  logic ev_clear, ev_load, ev_incr, ev_idle;
  assign ev_clear = clr;
  assign ev_load  = ld & ~clr;
  assign ev_incr  = inc & ~ld & ~clr;
  assign ev_idle  = ~clr & ~ld & ~inc;

  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return v + {{(W-1){1'b0}}, 1'b1};
  endfunction

  logic [W-1:0] q_next;
  always_comb begin
    q_next = q;
    if (ev_clear)     q_next = '0;
    else if (ev_load) q_next = d;
    else if (ev_incr) q_next = bump(q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0)); // R6
  AST_LOAD_OVER_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> (q == $past(d))); // R4
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && !clr && (q == {W{1'b1}})) |=> (q == '0)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idle |=> $stable(q)); // R9
endmodule

// File: rtl/sbd_word_mem.sv
`timescale 1ns/1ps
module sbd_word_mem #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  assign rdata = store[addr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((addr != $past(addr)) || (rdata == $past(wdata)))); // R7
endmodule

// File: rtl/sbd_bus_mux.sv
`timescale 1ns/1ps
module sbd_bus_mux
  import sbd_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic [2:0]    sel,
  input  logic [AW-1:0] ar,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] dr,
  input  logic [DW-1:0] ac,
  input  logic [DW-1:0] ir,
  input  logic [DW-1:0] tr,
  input  logic [DW-1:0] mem_rd,
  output logic [DW-1:0] bus
);
  localparam int NSRC = 7;
  logic [6:0]    src_en;
  logic [DW-1:0] src [NSRC];

  assign src_en = sel_decode(sel);
  assign src[0] = {{(DW-AW){1'b0}}, ar};
  assign src[1] = {{(DW-AW){1'b0}}, pc};
  assign src[2] = dr;
  assign src[3] = ac;
  assign src[4] = ir;
  assign src[5] = tr;
  assign src[6] = mem_rd;

  always_comb begin
    bus = '0;
    for (int k = 0; k < NSRC; k++) begin
      bus = bus | (src[k] & {DW{src_en[k]}});
    end
  end

  always_comb begin
    AST_ONE_DRIVER: assert ($onehot0(src_en)); // R2
    AST_IDLE_ZERO: assert (sel != 3'd0 || bus == '0); // R2
  end
endmodule

// File: rtl/sbd_top.sv
`timescale 1ns/1ps
module sbd_top
  import sbd_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          bus_sel,
  input  logic [NUM_REGS-1:0] reg_ld,
  input  logic [NUM_REGS-1:0] reg_inc,
  input  logic [NUM_REGS-1:0] reg_clr,
  input  logic                mem_we,
  input  logic [DW-1:0]       alu_result,
  output logic [DW-1:0]       bus_data,
  output logic [AW-1:0]       ar_q,
  output logic [AW-1:0]       pc_q,
  output logic [DW-1:0]       dr_q,
  output logic [DW-1:0]       ac_q,
  output logic [DW-1:0]       ir_q,
  output logic [DW-1:0]       tr_q
);
  localparam int NADDR = 2;
  localparam int NDATA = NUM_REGS - NADDR;

  logic [AW-1:0] addr_q [NADDR];
  logic [DW-1:0] data_q [NDATA];
  logic [DW-1:0] bus_w;
  logic [DW-1:0] mem_rd;

  // 12-bit registers: AR (0), PC (1), loaded from low bus bits
  for (genvar ga = 0; ga < NADDR; ga++) begin : g_addr
    sbd_reg_cell #(.W(AW)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .clr(reg_clr[ga]), .ld(reg_ld[ga]), .inc(reg_inc[ga]),
      .d(bus_w[AW-1:0]), .q(addr_q[ga])
    );
  end

  // 16-bit registers: DR, AC, IR, TR; AC takes the arithmetic result
  for (genvar gd = 0; gd < NDATA; gd++) begin : g_data
    localparam int RI = gd + NADDR;
    logic [DW-1:0] d_in;
    if (RI == IDX_AC) begin : g_acc
      assign d_in = alu_result;
    end else begin : g_plain
      assign d_in = bus_w;
    end
    sbd_reg_cell #(.W(DW)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .clr(reg_clr[RI]), .ld(reg_ld[RI]), .inc(reg_inc[RI]),
      .d(d_in), .q(data_q[gd])
    );
  end

  sbd_word_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we),
    .addr(addr_q[IDX_AR]), .wdata(bus_w), .rdata(mem_rd)
  );

  sbd_bus_mux #(.DW(DW), .AW(AW)) u_mux (
    .sel(bus_sel),
    .ar(addr_q[IDX_AR]), .pc(addr_q[IDX_PC]),
    .dr(data_q[IDX_DR-NADDR]), .ac(data_q[IDX_AC-NADDR]),
    .ir(data_q[IDX_IR-NADDR]), .tr(data_q[IDX_TR-NADDR]),
    .mem_rd(mem_rd), .bus(bus_w)
  );

  assign bus_data = bus_w;
  assign ar_q = addr_q[IDX_AR];
  assign pc_q = addr_q[IDX_PC];
  assign dr_q = data_q[IDX_DR-NADDR];
  assign ac_q = data_q[IDX_AC-NADDR];
  assign ir_q = data_q[IDX_IR-NADDR];
  assign tr_q = data_q[IDX_TR-NADDR];

  AST_ADDR_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == SEL_AR || bus_sel == SEL_PC) |-> (bus_w[DW-1:AW] == '0)); // R3
  AST_MEM_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == SEL_MEM) |-> (bus_w == mem_rd)); // R8
  AST_RESET_CLEAN: assert property (@(posedge clk)
    $rose(rst_n) |-> (ar_q == '0 && pc_q == '0 && ac_q == '0)); // R1
endmodule

// File: tb/sbd_top_tb.sv
`timescale 1ns/1ps
module sbd_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_sel = '0;
  logic [5:0]  reg_ld = '0, reg_inc = '0, reg_clr = '0;
  logic        mem_we = 1'b0;
  logic [15:0] alu_result = '0;
  logic [15:0] bus_data;
  logic [11:0] ar_q, pc_q;
  logic [15:0] dr_q, ac_q, ir_q, tr_q;

  always #10 clk = ~clk;  // 50 MHz

  sbd_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel),
    .reg_ld(reg_ld), .reg_inc(reg_inc), .reg_clr(reg_clr),
    .mem_we(mem_we), .alu_result(alu_result), .bus_data(bus_data),
    .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q), .ir_q(ir_q), .tr_q(tr_q)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  // behavioural model: register values as integers, memory as associative array
  int m_reg [6];
  int m_width [6] = '{12, 12, 16, 16, 16, 16};
  int mem_m [int];
  string last_tag [6];

  function automatic int mask_of(int i);
    return (1 << m_width[i]) - 1;
  endfunction

  function automatic int dut_reg(int i);
    case (i)
      0: return int'(ar_q);
      1: return int'(pc_q);
      2: return int'(dr_q);
      3: return int'(ac_q);
      4: return int'(ir_q);
      default: return int'(tr_q);
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_regs();
    for (int i = 0; i < 6; i++) check(last_tag[i], $sformatf("reg%0d", i), dut_reg(i), m_reg[i]);
  endtask

  // one clock: compare registers, apply inputs, compare bus, advance model
  task automatic cyc(input logic [2:0] sel, input logic [5:0] ld, input logic [5:0] inc,
                     input logic [5:0] clr, input logic we, input logic [15:0] alu);
    int eb;
    bit known;
    @(negedge clk);
    check_regs();
    bus_sel = sel; reg_ld = ld; reg_inc = inc; reg_clr = clr; mem_we = we; alu_result = alu;
    #1;
    known = 1;
    case (sel)
      3'd0: eb = 0;
      3'd7: begin
        if (mem_m.exists(m_reg[0])) eb = mem_m[m_reg[0]];
        else begin known = 0; eb = 0; end
      end
      default: eb = m_reg[sel - 1];
    endcase
    if (known) begin
      if (sel == 3'd7)                    check("R8", "bus mem read (R7 data)", int'(bus_data), eb);
      else if (sel == 3'd1 || sel == 3'd2) check("R3", "bus addr src", int'(bus_data), eb);
      else                                 check("R2", "bus select", int'(bus_data), eb);
    end
    if (we && known) mem_m[m_reg[0]] = eb;
    for (int i = 0; i < 6; i++) begin
      if (clr[i]) begin
        m_reg[i] = 0; last_tag[i] = "R6";
      end else if (ld[i]) begin
        m_reg[i] = ((i == 3) ? int'(alu) : eb) & mask_of(i);
        last_tag[i] = (inc[i]) ? "R6" : "R4";
        if (!known && i != 3) m_reg[i] = dut_reg_next_unknown(i);
      end else if (inc[i]) begin
        m_reg[i] = (m_reg[i] + 1) & mask_of(i); last_tag[i] = "R5";
      end else begin
        last_tag[i] = "R9";
      end
    end
  endtask

  // never called with a load of an unwritten memory word: bench avoids it
  function automatic int dut_reg_next_unknown(int i);
    return m_reg[i];
  endfunction

  initial begin
    for (int i = 0; i < 6; i++) begin m_reg[i] = 0; last_tag[i] = "R1"; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 6; i++) check("R1", "reset value", dut_reg(i), 0);
    rst_n = 1'b1;
    // R10 bit order: AR0 PC1 DR2 AC3 IR4 TR5
    cyc(3'd0, 6'b001000, 0, 0, 0, 16'hABCD);         // R4 AC from alu
    cyc(3'd4, 6'b110111, 0, 0, 0, 16'h0);            // R4 AR/PC low bits, DR/IR/TR full
    cyc(3'd1, 6'b000100, 0, 0, 0, 16'h0);            // R3 AR zero-extended into DR
    cyc(3'd2, 6'b100000, 0, 0, 0, 16'h0);            // R3 PC into TR
    cyc(3'd0, 6'b001000, 0, 0, 0, 16'hFFFF);
    cyc(3'd4, 6'b000110, 0, 0, 0, 16'h0);            // PC=FFF, DR=FFFF
    cyc(3'd0, 0, 6'b000110, 0, 0, 16'h0);            // R5 both wrap to 0
    cyc(3'd0, 0, 0, 0, 0, 16'h0);                    // R9 hold
    cyc(3'd4, 6'b110000, 6'b010000, 6'b100000, 0, 0); // R6 TR clear wins, IR load wins
    cyc(3'd0, 6'b001000, 0, 0, 0, 16'h0123);
    cyc(3'd4, 6'b000001, 0, 0, 0, 16'h0);            // AR=123
    cyc(3'd0, 6'b001000, 0, 0, 0, 16'h5A5A);
    cyc(3'd4, 0, 0, 0, 1, 16'h0);                    // R7 write 5A5A @123
    cyc(3'd0, 6'b001000, 0, 0, 0, 16'h0);
    cyc(3'd7, 6'b000100, 0, 0, 0, 16'h0);            // R8 read into DR
    cyc(3'd0, 0, 6'b000001, 0, 0, 16'h0);            // AR=124
    cyc(3'd3, 0, 0, 0, 1, 16'h0);                    // R7 DR -> mem[124]
    cyc(3'd0, 6'b000001, 0, 0, 0, 16'h0);            // AR=0 via zero bus
    cyc(3'd0, 0, 0, 0, 1, 16'h0);                    // mem[0]=0
    cyc(3'd0, 0, 6'b000001, 0, 0, 16'h0);
    cyc(3'd0, 0, 6'b000001, 0, 0, 16'h0);
    cyc(3'd0, 0, 6'b000001, 0, 0, 16'h0);
    cyc(3'd0, 0, 6'b000001, 0, 0, 16'h0);            // AR=4? keep reading checked below
    cyc(3'd0, 6'b001000, 0, 0, 0, 16'h0124);
    cyc(3'd4, 6'b000001, 0, 0, 0, 16'h0);            // AR=124
    cyc(3'd7, 6'b100000, 0, 0, 0, 16'h0);            // R8 read back 5A5A into TR
    // random traffic over a small address window
    for (int n = 0; n < 600; n++) begin
      logic [2:0] s;
      logic [5:0] l, c, k;
      logic w;
      s = 3'($urandom_range(0, 7));
      l = 6'($urandom) & 6'($urandom);
      c = 6'($urandom) & 6'($urandom) & 6'($urandom);
      k = 6'($urandom) & 6'($urandom) & 6'($urandom);
      w = ($urandom_range(0, 3) == 0);
      if (s == 3'd7 && !mem_m.exists(m_reg[0])) s = 3'd4;
      if (l[0] && !k[0]) begin s = (s == 3'd7) ? 3'd4 : s; end
      if (s == 3'd4 && l[0]) begin l[0] = 1'b0; k[0] = 1'b1; end
      cyc(s, l, c, k, w, 16'($urandom) & 16'h00FF);
    end
    @(negedge clk);
    check_regs();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule